// File: doc/BRIEF.md
# Per-Lane Metaframe CRC-32 Unit

This block protects one lane of a multi-lane serial link. The lane carries 64-bit words that are grouped into metaframes, and every metaframe closes with a diagnostic word. Each word comes with a 2-bit tag, so the diagnostic word can be found without looking at its payload. A CRC-32C runs over every word of the metaframe, including the diagnostic word itself. While that word is being hashed, its low 32-bit CRC field counts as zero.

On the transmit side, the block writes the finished checksum into the diagnostic word's CRC field. Every other word leaves the block unchanged, one cycle after it arrives. On the receive side, the block repeats the calculation over the incoming metaframe. It emits a one-cycle error pulse when the received field does not match. Each direction has its own enable. Because one instance serves one lane, a failing checksum points to a single lane.

Top module: `crc_lane_unit`

## Requirements
- R1: The checksum is CRC-32C with generator 0x1EDC6F41. The register is preset to all ones, and the result is the bitwise inverse of the final register. Bit 63 of each word is shifted in first, then bits 62 down to 0. Words enter in arrival order, one word per clock.
- R2: An accepted word with the start input high restarts the calculation from the preset, whatever state the previous metaframe left. A word that is both the start word and the diagnostic word forms a one-word metaframe.
- R3: A word whose tag is 2'b10 is the diagnostic word, and it closes the metaframe. Its bits [31:0] are hashed as zero. Tags 2'b00 (data), 2'b01 and 2'b11 (other control) are hashed unchanged.
- R4: With the transmit enable high, each accepted diagnostic word leaves with bits [31:0] replaced by the metaframe checksum and bits [63:32] unchanged. All other words leave unchanged. Output valid, tag and data appear exactly one cycle after the input word.
- R5: With the transmit enable low in the cycle a diagnostic word is accepted, that word leaves bit-for-bit unchanged.
- R6: With the receive enable high, the error output is high for exactly the one cycle after an accepted diagnostic word whose bits [31:0] differ from the recomputed checksum. A matching metaframe produces no pulse.
- R7: With the receive enable low in the cycle a diagnostic word is accepted, no error pulse is produced.
- R8: Cycles with valid low do not advance the calculation and produce no output word. A metaframe whose words have idle gaps between them gives the same checksum as the same words sent back-to-back.
- R9: While reset is active and in the first cycle after it, transmit output valid and the error output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| txEn | input | 1 | Enables checksum insertion |
| txInValid | input | 1 | Transmit input word valid |
| txInSom | input | 1 | Transmit word starts a metaframe |
| txInTag | input | 2 | Transmit word tag (2'b10 = diagnostic word) |
| txInData | input | 64 | Transmit input word |
| txOutValid | output | 1 | Transmit output word valid |
| txOutTag | output | 2 | Transmit output tag |
| txOutData | output | 64 | Transmit output word, with the checksum inserted |
| rxEn | input | 1 | Enables checksum checking |
| rxInValid | input | 1 | Receive word valid |
| rxInSom | input | 1 | Receive word starts a metaframe |
| rxInTag | input | 2 | Receive word tag (2'b10 = diagnostic word) |
| rxInData | input | 64 | Receive word |
| rxCrcErr | output | 1 | One-cycle pulse for a metaframe that fails the check |

## Verification
The bench aims at several corner cases, and each one catches a specific kind of faulty design:
- A start marker that arrives in the middle of a metaframe. A design that ignores the restart carries stale state forward and produces a wrong inserted checksum or a false error pulse.
- A one-word metaframe, whose start word is also its diagnostic word. This catches a design that applies the preset and the field masking in the wrong order.
- Metaframes with idle gaps between words. A design that advances on idle cycles corrupts the checksum.
- A corrupted CRC field and a corrupted payload word, each sent with the receive enable high and with it low. A design that compares the wrong field, misses the masking or ignores the enable shows up here through a missing or an extra pulse.

// File: rtl/crc_lane_pkg.sv
package crc_lane_pkg;

  localparam int unsigned WORD_W = 64;
  localparam int unsigned CRC_W  = 32;
  localparam logic [31:0] CRC32C_POLY = 32'h1EDC6F41;

  typedef enum logic [1:0] {
    TAG_DATA = 2'b00,
    TAG_CTRL = 2'b01,
    TAG_DIAG = 2'b10,
    TAG_RSVD = 2'b11
  } wordTag_e;

  // Strobes from a path controller to its datapath and output stage.
  typedef struct packed {
    logic advance;   // accepted word: update the CRC register
    logic restart;   // accepted start word: hash from the preset
    logic diag;      // accepted diagnostic word: mask its CRC field
    logic apply;     // diagnostic word with the path enabled
  } crcStrobe_t;

endpackage

// File: rtl/crc_lane_ctrl.sv
module crc_lane_ctrl
  import crc_lane_pkg::*;
(
  input  logic       inValid,
  input  logic       inSom,
  input  logic [1:0] inTag,
  input  logic       enable,
  output crcStrobe_t strb
);

  logic isDiag;

  assign isDiag = inValid && (inTag == TAG_DIAG);

  always_comb begin
    strb         = '0;
    strb.advance = inValid;
    strb.restart = inValid && inSom;
    strb.diag    = isDiag;
    strb.apply   = isDiag && enable;
  end

endmodule

// File: rtl/crc_lane_dp.sv
module crc_lane_dp
  import crc_lane_pkg::*;
#(
  parameter int unsigned            DATA_W = WORD_W,
  parameter int unsigned            SUM_W  = CRC_W,
  parameter logic [SUM_W-1:0]       POLY   = CRC32C_POLY
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobe_t        strb,
  input  logic [DATA_W-1:0] inData,
  output logic [SUM_W-1:0]  crcOut
);

  localparam int unsigned UPPER_W = DATA_W - SUM_W;

  logic [SUM_W-1:0]  crcReg;
  logic [SUM_W-1:0]  seed;
  logic [SUM_W-1:0]  crcNext;
  logic [DATA_W-1:0] hashWord;

  // MSB-first serial division, unrolled across one word.
  function automatic logic [SUM_W-1:0] crcStep(input logic [SUM_W-1:0]  start,
                                               input logic [DATA_W-1:0] word);
    logic [SUM_W-1:0] acc;
    acc = start;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (acc[SUM_W-1] ^ word[i]) acc = {acc[SUM_W-2:0], 1'b0} ^ POLY;
      else                        acc = {acc[SUM_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  assign seed     = strb.restart ? {SUM_W{1'b1}} : crcReg;
  assign hashWord = strb.diag ? {inData[DATA_W-1 -: UPPER_W], {SUM_W{1'b0}}} : inData;
  assign crcNext  = crcStep(seed, hashWord);
  assign crcOut   = ~crcNext;

  always_ff @(posedge clk) begin
    if (!rstN)             crcReg <= {SUM_W{1'b1}};
    else if (strb.advance) crcReg <= crcNext;
  end

  // R8: idle cycles leave the running CRC untouched
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(crcReg));

endmodule

// File: rtl/crc_lane_tx_emit.sv
module crc_lane_tx_emit
  import crc_lane_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned SUM_W  = CRC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              apply,
  input  logic              inValid,
  input  logic [1:0]        inTag,
  input  logic [DATA_W-1:0] inData,
  input  logic [SUM_W-1:0]  crcIn,
  output logic              outValid,
  output logic [1:0]        outTag,
  output logic [DATA_W-1:0] outData
);

  localparam int unsigned UPPER_W = DATA_W - SUM_W;

  logic [DATA_W-1:0] wordOut;

  assign wordOut = apply ? {inData[DATA_W-1 -: UPPER_W], crcIn} : inData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outTag   <= '0;
      outData  <= '0;
    end else begin
      outValid <= inValid;
      outTag   <= inTag;
      outData  <= wordOut;
    end
  end

endmodule

// File: rtl/crc_lane_rx_judge.sv
module crc_lane_rx_judge
  import crc_lane_pkg::*;
#(
  parameter int unsigned SUM_W = CRC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             apply,
  input  logic [SUM_W-1:0] fieldIn,
  input  logic [SUM_W-1:0] crcIn,
  output logic             errPulse
);

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= apply && (fieldIn != crcIn);
  end

  // R6: a pulse only ever follows an enabled diagnostic word
  a_r6_err_after_diag: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(apply));

endmodule

// File: rtl/crc_lane_unit.sv
module crc_lane_unit
  import crc_lane_pkg::*;
#(
  parameter int unsigned      DATA_W = WORD_W,
  parameter int unsigned      SUM_W  = CRC_W,
  parameter logic [SUM_W-1:0] POLY   = CRC32C_POLY
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEn,
  input  logic              txInValid,
  input  logic              txInSom,
  input  logic [1:0]        txInTag,
  input  logic [DATA_W-1:0] txInData,
  output logic              txOutValid,
  output logic [1:0]        txOutTag,
  output logic [DATA_W-1:0] txOutData,
  input  logic              rxEn,
  input  logic              rxInValid,
  input  logic              rxInSom,
  input  logic [1:0]        rxInTag,
  input  logic [DATA_W-1:0] rxInData,
  output logic              rxCrcErr
);

  localparam int unsigned PATHS   = 2;   // 0 = transmit, 1 = receive
  localparam int unsigned UPPER_W = DATA_W - SUM_W;

  logic [PATHS-1:0]             pathValid;
  logic [PATHS-1:0]             pathSom;
  logic [PATHS-1:0]             pathEn;
  logic [PATHS-1:0][1:0]        pathTag;
  logic [PATHS-1:0][DATA_W-1:0] pathData;
  logic [PATHS-1:0][SUM_W-1:0]  pathCrc;
  crcStrobe_t                   pathStrb [PATHS];

  assign pathValid = {rxInValid, txInValid};
  assign pathSom   = {rxInSom,   txInSom};
  assign pathEn    = {rxEn,      txEn};
  assign pathTag   = {rxInTag,   txInTag};
  assign pathData  = {rxInData,  txInData};

  for (genvar p = 0; p < PATHS; p++) begin : g_path
    crc_lane_ctrl ctrl_i (
      .inValid (pathValid[p]),
      .inSom   (pathSom[p]),
      .inTag   (pathTag[p]),
      .enable  (pathEn[p]),
      .strb    (pathStrb[p])
    );

    crc_lane_dp #(.DATA_W(DATA_W), .SUM_W(SUM_W), .POLY(POLY)) dp_i (
      .clk    (clk),
      .rstN   (rstN),
      .strb   (pathStrb[p]),
      .inData (pathData[p]),
      .crcOut (pathCrc[p])
    );
  end

  crc_lane_tx_emit #(.DATA_W(DATA_W), .SUM_W(SUM_W)) txEmit_i (
    .clk      (clk),
    .rstN     (rstN),
    .apply    (pathStrb[0].apply),
    .inValid  (txInValid),
    .inTag    (txInTag),
    .inData   (txInData),
    .crcIn    (pathCrc[0]),
    .outValid (txOutValid),
    .outTag   (txOutTag),
    .outData  (txOutData)
  );

  crc_lane_rx_judge #(.SUM_W(SUM_W)) rxJudge_i (
    .clk      (clk),
    .rstN     (rstN),
    .apply    (pathStrb[1].apply),
    .fieldIn  (rxInData[SUM_W-1:0]),
    .crcIn    (pathCrc[1]),
    .errPulse (rxCrcErr)
  );

  // R4: words other than the diagnostic word pass unchanged after one cycle
  a_r4_plain_word_through: assert property (@(posedge clk) disable iff (!rstN)
    txInValid && (txInTag != TAG_DIAG) |=> txOutValid && (txOutData == $past(txInData)));

  // R4: the upper half of the diagnostic word is never altered
  a_r4_diag_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    txInValid && (txInTag == TAG_DIAG) |=>
      txOutData[DATA_W-1 -: UPPER_W] == $past(txInData[DATA_W-1 -: UPPER_W]));

  // R5: with insertion disabled every word is copied bit for bit
  a_r5_disabled_through: assert property (@(posedge clk) disable iff (!rstN)
    txInValid && !txEn |=> txOutData == $past(txInData));

  // R7: no pulse follows a cycle with checking disabled
  a_r7_no_err_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !rxCrcErr);

  // R8: no output word follows an idle input cycle
  a_r8_no_word_on_idle: assert property (@(posedge clk) disable iff (!rstN)
    !txInValid |=> !txOutValid);

endmodule

// File: tb/crc_lane_unit_tb_top.sv
`timescale 1ns/1ps
module crc_lane_unit_tb_top;

  localparam logic [31:0] GEN = 32'h1EDC6F41;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txEn = 1'b0, txInValid = 1'b0, txInSom = 1'b0;
  logic [1:0]  txInTag = '0;
  logic [63:0] txInData = '0;
  logic        txOutValid;
  logic [1:0]  txOutTag;
  logic [63:0] txOutData;
  logic        rxEn = 1'b0, rxInValid = 1'b0, rxInSom = 1'b0;
  logic [1:0]  rxInTag = '0;
  logic [63:0] rxInData = '0;
  logic        rxCrcErr;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string phaseReq = "R9";

  always #4 clk = ~clk;

  crc_lane_unit dut_i (
    .clk(clk), .rstN(rstN),
    .txEn(txEn), .txInValid(txInValid), .txInSom(txInSom), .txInTag(txInTag),
    .txInData(txInData), .txOutValid(txOutValid), .txOutTag(txOutTag),
    .txOutData(txOutData),
    .rxEn(rxEn), .rxInValid(rxInValid), .rxInSom(rxInSom), .rxInTag(rxInTag),
    .rxInData(rxInData), .rxCrcErr(rxCrcErr)
  );

  // Reference: R1 bit-serial CRC-32C, one bit at a time from bit 63.
  function automatic logic [31:0] refHash(input logic [31:0] state, input logic [63:0] w);
    logic [31:0] s = state;
    for (int k = 0; k < 64; k++) begin
      bit fb = s[31] ^ w[63 - k];
      s = s << 1;
      if (fb) s ^= GEN;
    end
    return s;
  endfunction

  function automatic logic [63:0] refMask(input logic [1:0] tag, input logic [63:0] w);
    return (tag == 2'b10) ? {w[63:32], 32'h0} : w;   // R3
  endfunction

  // Cycle model, updated on each rising edge from the inputs it sees.
  logic [31:0] mTx, mRx;
  logic        expTxValid, expErr;
  logic [1:0]  expTxTag;
  logic [63:0] expTxData;

  always @(posedge clk) begin
    if (!rstN) begin
      mTx = '1; mRx = '1;
      expTxValid = 1'b0; expErr = 1'b0; expTxTag = '0; expTxData = '0;
    end else begin
      logic [31:0] nx;
      expTxValid = txInValid;
      if (txInValid) begin
        nx = refHash(txInSom ? 32'hFFFF_FFFF : mTx, refMask(txInTag, txInData));
        mTx = nx;
        expTxTag  = txInTag;
        expTxData = (txInTag == 2'b10 && txEn) ? {txInData[63:32], ~nx} : txInData;
      end
      expErr = 1'b0;
      if (rxInValid) begin
        nx = refHash(rxInSom ? 32'hFFFF_FFFF : mRx, refMask(rxInTag, rxInData));
        mRx = nx;
        if (rxInTag == 2'b10 && rxEn && rxInData[31:0] != ~nx) expErr = 1'b1;
      end
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) begin
        checks++;
        if (txOutValid !== 1'b0 || rxCrcErr !== 1'b0) begin
          failures++;
          $display("FAIL R9 reset outputs act=%b%b exp=00", txOutValid, rxCrcErr);
        end
      end else begin
        checks++;
        if (txOutValid !== expTxValid) begin
          failures++;
          $display("FAIL %s txOutValid act=%b exp=%b", phaseReq, txOutValid, expTxValid);
        end else if (expTxValid && (txOutData !== expTxData || txOutTag !== expTxTag)) begin
          failures++;
          $display("FAIL %s txOut act=%h/%h exp=%h/%h", phaseReq, txOutTag, txOutData,
                   expTxTag, expTxData);
        end
        checks++;
        if (rxCrcErr !== expErr) begin
          failures++;
          $display("FAIL %s rxCrcErr act=%b exp=%b", phaseReq, rxCrcErr, expErr);
        end
      end
    end
  end

  function automatic logic [1:0] tagFor(int i, int len);
    if (i == len - 1) return 2'b10;
    if (i == 0)       return 2'b01;
    if (i % 3 == 2)   return 2'b11;
    return 2'b00;
  endfunction

  task automatic txWord(bit som, logic [1:0] tag, logic [63:0] d);
    @(negedge clk);
    txInValid = 1'b1; txInSom = som; txInTag = tag; txInData = d;
  endtask

  task automatic txIdle();
    @(negedge clk);
    txInValid = 1'b0; txInSom = 1'b0; txInData = {$urandom, $urandom};
  endtask

  task automatic txFrame(int len, bit gaps);
    for (int i = 0; i < len; i++) begin
      txWord(i == 0, tagFor(i, len), {$urandom, $urandom});
      if (gaps && (i % 2 == 1)) txIdle();
    end
    txIdle();
  endtask

  task automatic rxWord(bit som, logic [1:0] tag, logic [63:0] d);
    @(negedge clk);
    rxInValid = 1'b1; rxInSom = som; rxInTag = tag; rxInData = d;
  endtask

  task automatic rxIdle();
    @(negedge clk);
    rxInValid = 1'b0; rxInSom = 1'b0; rxInData = {$urandom, $urandom};
  endtask

  // corrupt: 0 none, 1 flip a CRC field bit, 2 flip a payload bit
  task automatic rxFrame(int len, int corrupt, bit gaps);
    logic [63:0] w [16];
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      w[i] = {$urandom, $urandom};
      c = refHash(c, refMask(tagFor(i, len), w[i]));
    end
    w[len-1][31:0] = ~c;
    if (corrupt == 1) w[len-1][5] = ~w[len-1][5];
    if (corrupt == 2) w[0][40] = ~w[0][40];
    for (int i = 0; i < len; i++) begin
      rxWord(i == 0, tagFor(i, len), w[i]);
      if (gaps && (i % 2 == 1)) rxIdle();
    end
    rxIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    txEn = 1'b1; rxEn = 1'b1;

    phaseReq = "R1 R3 R4";
    txFrame(6, 0);
    txFrame(4, 0);
    phaseReq = "R1 R3 R6";
    rxFrame(6, 0, 0);
    rxFrame(5, 1, 0);
    rxFrame(7, 2, 0);

    phaseReq = "R8";
    txFrame(7, 1);
    rxFrame(6, 0, 1);
    rxFrame(6, 1, 1);

    phaseReq = "R2";
    txWord(1, 2'b01, {$urandom, $urandom});
    txWord(0, 2'b00, {$urandom, $urandom});
    txFrame(4, 0);
    rxWord(1, 2'b01, {$urandom, $urandom});
    rxWord(0, 2'b00, {$urandom, $urandom});
    rxFrame(4, 0, 0);
    txWord(1, 2'b10, {$urandom, $urandom});
    txIdle();
    rxFrame(1, 0, 0);
    rxFrame(1, 1, 0);

    phaseReq = "R5";
    txEn = 1'b0;
    txFrame(5, 0);
    phaseReq = "R7";
    rxEn = 1'b0;
    rxFrame(5, 1, 0);
    rxFrame(5, 2, 0);

    phaseReq = "R4 R6";
    txEn = 1'b1; rxEn = 1'b1;
    fork
      txFrame(8, 0);
      rxFrame(8, 1, 0);
    join
    fork
      txFrame(3, 1);
      rxFrame(3, 0, 1);
    join

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule